// File: doc/BRIEF.md
# Coin Accumulation State Machine

This block counts coins for a vending unit until at least 35 cents has come in. On every rising clock edge it samples two single-cycle detect pulses, one for a 25-cent coin and one for a 10-cent coin. It keeps the running credit as a 3-bit code in D flip-flops and raises `paid_o` once the credit reaches the threshold.

There are five states: no credit, 10 cents, 20 cents, a shared state for 25 and 30 cents, and a paid state. The paid state holds until a synchronous reset clears it. Change return, dispensing, debouncing and coin checks are done elsewhere.

Top module: `coin_tally`

## Requirements
- R1: A synchronous active-high `rst_i` at a rising edge sets `state_o` to 3'b000 and drives `paid_o` low from the next cycle on.
- R2: In a cycle with neither coin pulse, `state_o` keeps its value at the next edge. This holds in every state.
- R3: A 10-cent pulse alone moves 3'b000 to 3'b001, 3'b001 to 3'b010, 3'b010 to 3'b011, and 3'b011 to the paid code 3'b100.
- R4: A 25-cent pulse moves 3'b000 to 3'b011, and moves 3'b001, 3'b010 or 3'b011 to the paid code 3'b100.
- R5: Once bit 2 of `state_o` is set, it stays set for any input until reset. Codes 3'b101, 3'b110 and 3'b111 are paid codes too.
- R6: When both coin pulses come in the same cycle, the 25-cent pulse wins and the 10-cent pulse is dropped.
- R7: `paid_o` is high exactly when bit 2 of `state_o` is set. It depends only on the stored state, and it rises only in the cycle after a coin pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| quarter_i | input | 1 | One-cycle pulse: a 25-cent coin was seen |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was seen |
| state_o | output | 3 | Stored credit code |
| paid_o | output | 1 | High once at least 35 cents has been received |

## Verification
The assertions assume that each coin pulse lasts one cycle and stands for one coin. They also assume that reset is the only way out of the paid state, so no illegal code is ever loaded from outside. The stimulus drives each coin input for exactly one clock. It sends both pulses together only on purpose, to test the 25-cent priority, and it changes inputs only on falling edges. The coin orders it tries reach 25, 30 and 35 cents and higher by different paths, and each path starts from a fresh reset.

// File: rtl/coin_tally.sv
module coin_tally #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              quarter_i,
  input  logic              dime_i,
  output logic [CODE_W-1:0] state_o,
  output logic              paid_o
);
  localparam logic [CODE_W-1:0] S_ZERO = CODE_W'(0);
  localparam logic [CODE_W-1:0] S_TEN  = CODE_W'(1);
  localparam logic [CODE_W-1:0] S_TWTY = CODE_W'(2);
  localparam logic [CODE_W-1:0] S_QRTR = CODE_W'(3);
  localparam logic [CODE_W-1:0] S_PAID = CODE_W'(4);

  logic [CODE_W-1:0] cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (cur_q[CODE_W-1]) nxt = cur_q;
    else if (quarter_i) nxt = (cur_q == S_ZERO) ? S_QRTR : S_PAID;
    else if (dime_i) begin
      case (cur_q)
        S_ZERO:  nxt = S_TEN;
        S_TEN:   nxt = S_TWTY;
        S_TWTY:  nxt = S_QRTR;
        default: nxt = S_PAID;
      endcase
    end
  end

  always_ff @(posedge clk_i)
    if (rst_i) cur_q <= S_ZERO;
    else       cur_q <= nxt;

  assign state_o = cur_q;
  assign paid_o  = cur_q[CODE_W-1];

  assert_reset_clears_R1: assert property (@(posedge clk_i)
    rst_i |=> (state_o == S_ZERO && !paid_o));
  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!quarter_i && !dime_i) |=> $stable(state_o));
  assert_dime_steps_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (dime_i && !quarter_i && !state_o[CODE_W-1]) |=>
      (state_o == $past(state_o) + CODE_W'(1)));
  assert_quarter_from_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (quarter_i && state_o == S_ZERO) |=> (state_o == S_QRTR));
  assert_paid_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    state_o[CODE_W-1] |=> state_o[CODE_W-1]);
  assert_quarter_wins_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (quarter_i && dime_i && state_o != S_ZERO) |=> paid_o);
  assert_paid_after_coin_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(paid_o) |-> $past(quarter_i || dime_i));
endmodule

// File: tb/sim_coin_tally.sv
module sim_coin_tally;
  localparam time PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 5000;

  logic clk = 1'b0, rst = 1'b1, q = 1'b0, d = 1'b0;
  logic [2:0] state;
  logic paid;
  int checks = 0, failures = 0;
  int credit = 0;
  bit ref_paid = 1'b0;
  bit finished = 1'b0;

  coin_tally u0 (.clk_i(clk), .rst_i(rst), .quarter_i(q), .dime_i(d),
                 .state_o(state), .paid_o(paid));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [2:0] ref_code();
    if (ref_paid) return 3'b100;
    if (credit == 0) return 3'b000;
    if (credit == 10) return 3'b001;
    if (credit == 20) return 3'b010;
    return 3'b011;
  endfunction

  task automatic step(input bit r, input bit qq, input bit dd, input string tag);
    rst = r; q = qq; d = dd;
    @(posedge clk);
    if (r) begin credit = 0; ref_paid = 0; end
    else if (!ref_paid) begin
      if (qq) credit += 25;
      else if (dd) credit += 10;
      if (credit >= 35) ref_paid = 1;
    end
    @(negedge clk);
    checks++;
    if (state !== ref_code()) begin
      failures++;
      $display("FAIL %s state actual=%b expected=%b", tag, state, ref_code());
    end
    checks++;
    if (paid !== ref_paid) begin
      failures++;
      $display("FAIL %s R7 paid actual=%b expected=%b", tag, paid, ref_paid);
    end
  endtask

  initial begin
    #(PERIOD*WATCHDOG_CYC);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, "R1 reset");
    step(0, 0, 0, "R2 idle zero");
    step(0, 0, 0, "R2 idle zero");
    step(0, 0, 1, "R3 dime 0->10");
    step(0, 0, 0, "R2 idle ten");
    step(0, 0, 1, "R3 dime 10->20");
    step(0, 0, 1, "R3 dime 20->30");
    step(0, 0, 0, "R2 idle 25/30");
    step(0, 0, 1, "R3 dime 30->paid");
    step(0, 0, 0, "R5 idle paid");
    step(0, 0, 1, "R5 dime in paid");
    step(0, 1, 0, "R5 quarter in paid");
    step(0, 1, 1, "R5 both in paid");
    step(1, 1, 1, "R1 reset from paid");
    step(0, 1, 0, "R4 quarter 0->25");
    step(0, 0, 1, "R3 dime 25->paid");
    step(1, 0, 0, "R1 reset");
    step(0, 0, 1, "R3 dime");
    step(0, 1, 0, "R4 quarter 10->paid");
    step(1, 0, 0, "R1 reset");
    step(0, 0, 1, "R3 dime");
    step(0, 0, 1, "R3 dime");
    step(0, 1, 0, "R4 quarter 20->paid");
    step(1, 0, 0, "R1 reset");
    step(0, 1, 0, "R4 quarter 0->25");
    step(0, 1, 0, "R4 quarter 25->paid");
    step(1, 0, 0, "R1 reset");
    step(0, 1, 1, "R6 both at zero");
    step(0, 0, 0, "R2 idle 25");
    step(0, 1, 1, "R6 both at 25");
    step(1, 0, 0, "R1 reset");
    step(0, 0, 1, "R3 dime");
    step(0, 1, 1, "R6 both at 10");
    step(0, 0, 1, "R3 dime");
    step(1, 0, 1, "R1 reset beats dime");
    step(0, 0, 0, "R2 idle after reset");
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule